// File: doc/BRIEF.md
# Not-Most-Recently-Used Victim Pointer

This block picks the replacement victim for a small fully associative table, such as a TLB or a tiny cache, that has a fixed number of entries (64 by default). One register holds an entry index, and that index is the victim candidate. The lookup logic around the block reports every entry it uses with a strobe and the index of that entry. A fill counts as a use too: when the table writes new contents into the victim slot, it reports that slot on the same strobe.

The rule that moves the pointer is small. A use of the entry the pointer names moves the pointer on by one, and the pointer goes back to entry 0 after the last entry. A use of any other entry leaves the pointer where it is. So the pointer never names the entry used most recently, and the block keeps no recency history beyond the pointer itself. The victim output comes straight from the pointer register, so it is stable for a whole clock cycle.

Top module: `nmru_victim_ptr`

## Requirements
- R1: While `rst` is high at a rising clock edge, the victim index becomes 0 at that edge and stays 0 until a use after reset moves it.
- R2: If `touch_vld` is high and `touch_idx` equals the current victim index at a rising edge, the victim index after that edge is the previous value plus one. A fill into the victim slot is reported this way.
- R3: If `touch_vld` is high and `touch_idx` is any other index, the victim index stays the same.
- R4: When entry ENTRIES-1 (63 by default) is used while the pointer names it, the pointer goes back to entry 0.
- R5: While `touch_vld` is low, `touch_idx` is ignored and the victim index keeps its value, whatever index is present.
- R6: Once at least one use has been reported since reset, the victim index never equals the index of the most recent use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| touch_vld | input | 1 | High for one cycle for each entry use (lookup hit or fill) |
| touch_idx | input | IW ($clog2(ENTRIES), 6 by default) | Index of the entry that was used |
| victim_idx | output | IW | Registered replacement candidate |

## Verification
The bench builds the block with the default of 64 entries and a 6-bit index. With that size, a run of 64 consecutive uses of the pointed entry reaches the wrap from 63 to 0, and the random index draws can land on every entry. Random traffic picks the pointed entry about half the time, so advances and holds are both common. Directed steps cover an idle strobe carrying the pointed index, a reset in the middle of traffic, and the check after every cycle that the victim index never matches the last index used.

// File: rtl/nmru_pkg.sv
package nmru_pkg;
  // default table size
  localparam int unsigned NMRU_DEF_ENTRIES = 64;

  // index width for a table of n entries (at least one bit)
  function automatic int unsigned nmru_idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // true when n is a power of two
  function automatic bit nmru_is_pow2(input int unsigned n);
    return (n != 0) && ((n & (n - 1)) == 0);
  endfunction
endpackage

// File: rtl/nmru_match.sv
module nmru_match #(
  parameter int unsigned IW = 6
) (
  input  logic          touch_vld,
  input  logic [IW-1:0] touch_idx,
  input  logic [IW-1:0] ptr,
  output logic          adv
);
  // the pointer moves only when the entry it names is used
  always_comb adv = touch_vld && (touch_idx == ptr);
endmodule

// File: rtl/nmru_step.sv
module nmru_step #(
  parameter int unsigned ENTRIES = 64,
  localparam int unsigned IW = nmru_pkg::nmru_idx_w(ENTRIES)
) (
  input  logic [IW-1:0] cur,
  output logic [IW-1:0] nxt
);
  localparam logic [IW-1:0] LAST = IW'(ENTRIES - 1);

  generate
    if (nmru_pkg::nmru_is_pow2(ENTRIES)) begin : g_pow2
      // natural overflow gives the wrap
      always_comb nxt = cur + 1'b1;
    end else begin : g_mod
      always_comb nxt = (cur == LAST) ? '0 : cur + 1'b1;
    end
  endgenerate
endmodule

// File: rtl/nmru_ptr_reg.sv
module nmru_ptr_reg #(
  parameter int unsigned IW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  input  logic [IW-1:0] nxt,
  output logic [IW-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)      q <= '0;
    else if (adv) q <= nxt;
  end
endmodule

// File: rtl/nmru_victim_ptr.sv
module nmru_victim_ptr #(
  parameter int unsigned ENTRIES = nmru_pkg::NMRU_DEF_ENTRIES,
  localparam int unsigned IW = nmru_pkg::nmru_idx_w(ENTRIES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          touch_vld,
  input  logic [IW-1:0] touch_idx,
  output logic [IW-1:0] victim_idx
);
  localparam logic [IW-1:0] LAST = IW'(ENTRIES - 1);

  logic          adv;
  logic [IW-1:0] nxt;

  nmru_match #(.IW(IW)) u_match (
    .touch_vld (touch_vld),
    .touch_idx (touch_idx),
    .ptr       (victim_idx),
    .adv       (adv)
  );

  nmru_step #(.ENTRIES(ENTRIES)) u_step (
    .cur (victim_idx),
    .nxt (nxt)
  );

  nmru_ptr_reg #(.IW(IW)) u_reg (
    .clk (clk),
    .rst (rst),
    .adv (adv),
    .nxt (nxt),
    .q   (victim_idx)
  );

  // R1: reset forces entry 0
  a_r1_reset_zero: assert property (@(posedge clk)
    rst |=> victim_idx == '0);

  // R2, R4: use of the pointed entry moves on by one, wrapping after the last
  a_r2_advance: assert property (@(posedge clk) disable iff (rst)
    (touch_vld && touch_idx == victim_idx) |=>
      victim_idx == (($past(victim_idx) == LAST) ? '0 : IW'($past(victim_idx) + 1'b1)));

  // R3: use of another entry leaves the pointer alone
  a_r3_hold_other: assert property (@(posedge clk) disable iff (rst)
    (touch_vld && touch_idx != victim_idx) |=> $stable(victim_idx));

  // R5: idle strobe never moves the pointer
  a_r5_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !touch_vld |=> $stable(victim_idx));

  // R6: the victim is never the entry just used
  a_r6_not_mru: assert property (@(posedge clk) disable iff (rst)
    touch_vld |=> victim_idx != $past(touch_idx));

  // R4: pointer stays inside the table
  a_r4_in_range: assert property (@(posedge clk) disable iff (rst)
    victim_idx <= LAST);
endmodule

// File: tb/tb_nmru_victim_ptr.sv
module tb_nmru_victim_ptr;
  localparam int unsigned ENTRIES = 64;
  localparam int unsigned IW = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          touch_vld = 1'b0;
  logic [IW-1:0] touch_idx = '0;
  logic [IW-1:0] victim_idx;

  int tests = 0;
  int fails = 0;
  int exp_ptr = 0;
  int last_idx = 0;
  bit seen = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  nmru_victim_ptr #(.ENTRIES(ENTRIES)) dut (
    .clk        (clk),
    .rst        (rst),
    .touch_vld  (touch_vld),
    .touch_idx  (touch_idx),
    .victim_idx (victim_idx)
  );

  function automatic int model_next(input int p, input bit v, input int idx, input bit r);
    if (r) return 0;
    if (v && idx == p) return (p == ENTRIES - 1) ? 0 : p + 1;
    return p;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one clock: drive on falling edge, check just after the rising edge
  task automatic cyc(input bit r, input bit v, input int idx, input string req);
    @(negedge clk);
    rst = r;
    touch_vld = v;
    touch_idx = IW'(idx);
    @(posedge clk);
    #2;
    exp_ptr = model_next(exp_ptr, v, idx, r);
    if (r) seen = 1'b0;
    else if (v) begin last_idx = idx; seen = 1'b1; end
    check(int'(victim_idx) == exp_ptr, req, int'(victim_idx), exp_ptr);
    if (seen)
      check(int'(victim_idx) != last_idx, "R6", int'(victim_idx), last_idx);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    // R1: reset state
    cyc(1'b1, 1'b0, 0, "R1");
    cyc(1'b1, 1'b1, 0, "R1");
    // R3: other entry holds
    cyc(1'b0, 1'b1, 5, "R3");
    // R2: pointed entry advances
    cyc(1'b0, 1'b1, 0, "R2");
    // R5: idle strobe with pointed index holds
    cyc(1'b0, 1'b0, 1, "R5");
    cyc(1'b0, 1'b0, 1, "R5");
    // R4: walk to the last entry and wrap
    for (int k = 0; k < ENTRIES; k++) cyc(1'b0, 1'b1, exp_ptr, "R4");
    check(exp_ptr == 1, "R4", exp_ptr, 1);
    cyc(1'b0, 1'b1, ENTRIES - 1, "R3");
    // R1: reset in the middle of traffic
    cyc(1'b0, 1'b1, exp_ptr, "R2");
    cyc(1'b1, 1'b1, exp_ptr, "R1");
    cyc(1'b0, 1'b0, 0, "R1");
    // random traffic: half the uses hit the pointed entry
    for (int n = 0; n < 4000; n++) begin
      int sel;
      bit v;
      int idx;
      sel = int'($urandom_range(0, 9));
      v = (sel != 0);
      idx = (sel < 5) ? exp_ptr : int'($urandom_range(0, ENTRIES - 1));
      cyc(1'b0, v, idx, v ? ((idx == exp_ptr) ? "R2" : "R3") : "R5");
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule